// File: doc/BRIEF.md
# Effective Address Extension Fetcher

This block sits in the front end of an instruction decoder. For each operand it takes the 3-bit addressing-mode field, the 3-bit register field and the operand size. It works out how many 16-bit extension words follow the opcode and pulls exactly that many from the instruction word stream over a valid/ready handshake. It then presents the result:

- a decoded addressing-mode tag;
- the register number;
- the extension value, assembled to 32 bits;
- for program-counter-relative forms, the stream address at which the extension word was found;
- the stream address just past the last word consumed, so the caller can resume instruction fetch from there.

Encodings that do not exist are flagged as errors and nothing is fetched for them. The block does not form the final operand address and does not access operand data.

A one-cycle `start_i` pulse, given while the block is idle, captures the fields and the current stream address. A one-cycle `done_o` pulse marks completion. All result outputs then hold their values until the next accepted start.

Top module: `ea_ext_fetch`

## Requirements
- R1: Mode codes 0 to 4 consume no words. `word_ready_o` stays low, `done_o` pulses in the cycle after start, `tag_o` equals the mode code, `reg_o` equals the register field, `ext_o` is 0 and `error_o` is 0.
- R2: Mode 5 consumes one word and returns it sign-extended to 32 bits (tag 5). Mode 6 consumes one word and returns it zero-extended (tag 6).
- R3: Mode 7 with register 0 consumes one word and returns it sign-extended (tag 7). Mode 7 with register 1 consumes two words and returns the first word in bits 31:16 and the second in bits 15:0 (tag 8).
- R4: Mode 7 with register 2 (tag 9, word sign-extended) or register 3 (tag 10, word zero-extended) consumes one word. `pc_base_o` is the stream address of that word when it was taken. For every other mode `pc_base_o` is 0.
- R5: Mode 7 with register 4 (tag 11) consumes two words, high half first, when the size code is 2 (long). For size codes 0 (byte), 1 (word) and 3 it consumes one word, zero-extended.
- R6: Mode 7 with register 5, 6 or 7 sets `error_o`, sets tag 15, consumes no words and pulses `done_o` in the cycle after start, with `next_addr_o` equal to the start address.
- R7: During a fetch, `word_ready_o` stays high and nothing advances while `word_valid_i` is low. No more words are consumed than the decoded count.
- R8: `next_addr_o` is the start address plus 2 for each word consumed.
- R9: `done_o` is a single-cycle pulse. It follows the last handshake by one cycle. The results hold until the next accepted start. A start pulse while busy is ignored.
- R10: After reset, `busy_o`, `done_o`, `word_ready_o` and `error_o` are 0, and `ext_o`, `pc_base_o` and `next_addr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin decoding (accepted only when idle) |
| mode_i | input | 3 | Addressing-mode field |
| reg_i | input | 3 | Register field |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long, 3 treated as word |
| addr_i | input | 32 | Stream address of the next word at start |
| word_valid_i | input | 1 | Stream word available |
| word_data_i | input | 16 | Stream word |
| word_ready_o | output | 1 | Block takes the stream word this cycle |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Illegal encoding |
| tag_o | output | 4 | Decoded addressing-mode tag |
| reg_o | output | 3 | Register number |
| ext_o | output | 32 | Assembled extension value |
| pc_base_o | output | 32 | Address of the extension word for PC-relative forms |
| next_addr_o | output | 32 | Stream address after the consumed words |

## Verification
The hardest situations to reach from the ports are a start pulse that arrives while a two-word fetch is stalled, and a PC-relative fetch whose base must be captured while the stream withholds its word. The directed tasks hold `word_valid_i` low for several cycles right after start, and in one of them assert `start_i` with a different encoding during the stall. The checks then confirm that the original operation completes untouched, with the handshake count, base and final address of the first request.

// File: rtl/ea_ext_pkg.sv
package ea_ext_pkg;

  typedef enum logic [3:0] {
    TAG_DREG     = 4'd0,
    TAG_AREG     = 4'd1,
    TAG_IND      = 4'd2,
    TAG_POSTINC  = 4'd3,
    TAG_PREDEC   = 4'd4,
    TAG_DISP     = 4'd5,
    TAG_INDEX    = 4'd6,
    TAG_ABS_W    = 4'd7,
    TAG_ABS_L    = 4'd8,
    TAG_PC_DISP  = 4'd9,
    TAG_PC_INDEX = 4'd10,
    TAG_IMM      = 4'd11,
    TAG_BAD      = 4'd15
  } ea_tag_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } op_size_e;

  typedef struct packed {
    ea_tag_e    tag;
    logic [1:0] nwords;
    logic       sext;
    logic       pc_rel;
    logic       illegal;
  } ea_decode_t;

endpackage

// File: rtl/ea_mode_decode.sv
module ea_mode_decode
  import ea_ext_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic [2:0] reg_i,
  input  logic [1:0] size_i,
  output ea_decode_t dec_o
);

  always_comb begin
    dec_o         = '0;
    dec_o.tag     = ea_tag_e'({1'b0, mode_i});
    unique case (mode_i)
      3'd5: begin
        dec_o.nwords = 2'd1;
        dec_o.sext   = 1'b1;
      end
      3'd6: dec_o.nwords = 2'd1;
      3'd7: begin
        unique case (reg_i)
          3'd0: begin
            dec_o.tag    = TAG_ABS_W;
            dec_o.nwords = 2'd1;
            dec_o.sext   = 1'b1;
          end
          3'd1: begin
            dec_o.tag    = TAG_ABS_L;
            dec_o.nwords = 2'd2;
          end
          3'd2: begin
            dec_o.tag    = TAG_PC_DISP;
            dec_o.nwords = 2'd1;
            dec_o.sext   = 1'b1;
            dec_o.pc_rel = 1'b1;
          end
          3'd3: begin
            dec_o.tag    = TAG_PC_INDEX;
            dec_o.nwords = 2'd1;
            dec_o.pc_rel = 1'b1;
          end
          3'd4: begin
            dec_o.tag    = TAG_IMM;
            dec_o.nwords = (op_size_e'(size_i) == SZ_LONG) ? 2'd2 : 2'd1;
          end
          default: begin
            dec_o.tag     = TAG_BAD;
            dec_o.illegal = 1'b1;
          end
        endcase
      end
      default: ;
    endcase
  end

  // R6
  always_comb begin
    illegal_no_words_chk: assert (!dec_o.illegal || dec_o.nwords == 2'd0);
  end

endmodule

// File: rtl/ea_word_accum.sv
module ea_word_accum #(
  parameter int WORD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                sext_i,
  input  logic                push_i,
  input  logic [WORD_W-1:0]   word_i,
  output logic [2*WORD_W-1:0] ext_o
);

  localparam int EXT_W = 2 * WORD_W;

  logic [EXT_W-1:0] acc_q;
  logic             sext_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      sext_q <= 1'b0;
    end else if (clear_i) begin
      acc_q  <= '0;
      sext_q <= sext_i;
    end else if (push_i) begin
      acc_q <= {acc_q[WORD_W-1:0], word_i};
    end
  end

  // single-word signed forms widen from the low half
  assign ext_o = sext_q ? {{WORD_W{acc_q[WORD_W-1]}}, acc_q[WORD_W-1:0]} : acc_q;

  // R3
  push_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !clear_i) |=> acc_q[WORD_W-1:0] == $past(word_i) &&
                             acc_q[EXT_W-1:WORD_W] == $past(acc_q[WORD_W-1:0]));

  // R9
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_i && !clear_i) |=> $stable(acc_q));

endmodule

// File: rtl/ea_fetch_ctrl.sv
module ea_fetch_ctrl
  import ea_ext_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  ea_decode_t        dec_i,
  input  logic [2:0]        reg_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              clear_o,
  output logic              push_o,
  output logic              error_o,
  output ea_tag_e           tag_o,
  output logic [2:0]        reg_o,
  output logic [ADDR_W-1:0] pc_base_o,
  output logic [ADDR_W-1:0] next_addr_o
);

  localparam int ADDR_STEP = WORD_W / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_FINISH} st_e;

  st_e               state_q;
  logic [1:0]        remain_q;
  logic              pc_rel_q;
  logic              err_q;
  ea_tag_e           tag_q;
  logic [2:0]        reg_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] base_q;
  logic              accept;
  logic              hs;

  assign accept = start_i && (state_q == ST_IDLE);
  assign hs     = (state_q == ST_FETCH) && word_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      remain_q <= '0;
      pc_rel_q <= 1'b0;
      err_q    <= 1'b0;
      tag_q    <= TAG_DREG;
      reg_q    <= '0;
      addr_q   <= '0;
      base_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          tag_q    <= dec_i.tag;
          reg_q    <= reg_i;
          err_q    <= dec_i.illegal;
          pc_rel_q <= dec_i.pc_rel;
          remain_q <= dec_i.nwords;
          addr_q   <= addr_i;
          base_q   <= '0;
          state_q  <= (dec_i.illegal || dec_i.nwords == 2'd0) ? ST_FINISH : ST_FETCH;
        end
        ST_FETCH: if (word_valid_i) begin
          addr_q   <= addr_q + ADDR_W'(ADDR_STEP);
          remain_q <= remain_q - 2'd1;
          if (pc_rel_q) base_q <= addr_q;
          if (remain_q == 2'd1) state_q <= ST_FINISH;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign word_ready_o = (state_q == ST_FETCH);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_FINISH);
  assign clear_o      = accept;
  assign push_o       = hs;
  assign error_o      = err_q;
  assign tag_o        = tag_q;
  assign reg_o        = reg_q;
  assign pc_base_o    = base_q;
  assign next_addr_o  = addr_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs |=> next_addr_o == $past(next_addr_o) + ADDR_W'(ADDR_STEP));

  // R7
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_ready_o && !word_valid_i) |=> word_ready_o && $stable(next_addr_o));

  // R7
  ready_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ready_o |-> remain_q != 2'd0);

  // R6
  error_no_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !word_ready_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(next_addr_o) && $stable(tag_o) && $stable(pc_base_o));

  // R9
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !done_o) |=> $stable(tag_o) && $stable(reg_o));

endmodule

// File: rtl/ea_ext_fetch.sv
module ea_ext_fetch
  import ea_ext_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [2:0]          mode_i,
  input  logic [2:0]          reg_i,
  input  logic [1:0]          size_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                word_valid_i,
  input  logic [WORD_W-1:0]   word_data_i,
  output logic                word_ready_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                error_o,
  output logic [3:0]          tag_o,
  output logic [2:0]          reg_o,
  output logic [2*WORD_W-1:0] ext_o,
  output logic [ADDR_W-1:0]   pc_base_o,
  output logic [ADDR_W-1:0]   next_addr_o
);

  ea_decode_t dec;
  ea_tag_e    tag;
  logic       clear;
  logic       push;

  ea_mode_decode i_decode (
    .mode_i (mode_i),
    .reg_i  (reg_i),
    .size_i (size_i),
    .dec_o  (dec)
  );

  ea_fetch_ctrl #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) i_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .dec_i        (dec),
    .reg_i        (reg_i),
    .addr_i       (addr_i),
    .word_valid_i (word_valid_i),
    .word_ready_o (word_ready_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .clear_o      (clear),
    .push_o       (push),
    .error_o      (error_o),
    .tag_o        (tag),
    .reg_o        (reg_o),
    .pc_base_o    (pc_base_o),
    .next_addr_o  (next_addr_o)
  );

  ea_word_accum #(
    .WORD_W (WORD_W)
  ) i_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .sext_i  (dec.sext),
    .push_i  (push),
    .word_i  (word_data_i),
    .ext_o   (ext_o)
  );

  assign tag_o = tag;

  // R6
  bad_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (error_o == (tag_o == 4'd15)));

endmodule

// File: tb/test_ea_ext_fetch.sv
`timescale 1ns/1ps
module test_ea_ext_fetch;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [2:0]  reg_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] addr_i = '0;
  logic        word_valid_i = 1'b0;
  logic [15:0] word_data_i = '0;
  logic        word_ready_o, busy_o, done_o, error_o;
  logic [3:0]  tag_o;
  logic [2:0]  reg_o;
  logic [31:0] ext_o, pc_base_o, next_addr_o;

  int n_chk = 0;
  int n_bad = 0;
  int used, cyc;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  ea_ext_fetch i_ea_ext_fetch (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drives one operation; stall = cycles with valid low after start
  task automatic run_op(input logic [2:0] m, input logic [2:0] r, input logic [1:0] s,
                        input logic [31:0] a, input logic [15:0] w0, input logic [15:0] w1,
                        input int stall, input bit poke_start);
    int k = 0;
    bit hs;
    used = 0;
    cyc  = -1;
    @(negedge clk_i);
    mode_i = m; reg_i = r; size_i = s; addr_i = a; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int it = 0; it < 40; it++) begin
      if (done_o) begin
        cyc = it;
        break;
      end
      if (poke_start && it == 0) begin
        start_i = 1'b1; mode_i = 3'd0; reg_i = 3'd5; addr_i = 32'hDEAD0000;
      end else begin
        start_i = 1'b0;
      end
      if (k < stall) begin
        word_valid_i = 1'b0;
        if (!word_ready_o && busy_o) chk("R7 ready held in stall", word_ready_o, 1'b1);
        k++;
      end else begin
        word_valid_i = 1'b1;
        word_data_i  = (used == 0) ? w0 : (used == 1) ? w1 : 16'hBEEF;
      end
      hs = word_ready_o && word_valid_i;
      @(negedge clk_i);
      if (hs) used++;
    end
    start_i = 1'b0;
    word_valid_i = 1'b0;
    if (cyc < 0) begin
      n_chk++; n_bad++;
      $display("FAIL R9: done never seen, actual none expected pulse");
    end
  endtask

  task automatic t_reset();
    chk("R10 busy", busy_o, 0);
    chk("R10 done", done_o, 0);
    chk("R10 ready", word_ready_o, 0);
    chk("R10 error", error_o, 0);
    chk("R10 ext", ext_o, 0);
    chk("R10 pc_base", pc_base_o, 0);
    chk("R10 next_addr", next_addr_o, 0);
  endtask

  task automatic t_direct();
    for (int m = 0; m < 5; m++) begin
      run_op(3'(m), 3'(m + 2), 2'd2, 32'h100 + 32'(m), 16'h1111, 16'h2222, 0, 0);
      chk("R1 words", used, 0);
      chk("R1 latency", cyc, 0);
      chk("R1 tag", tag_o, m);
      chk("R1 reg", reg_o, m + 2);
      chk("R1 ext", ext_o, 0);
      chk("R1 error", error_o, 0);
      chk("R8 next_addr", next_addr_o, 32'h100 + 32'(m));
    end
  endtask

  task automatic t_disp_index();
    run_op(3'd5, 3'd3, 2'd1, 32'h2000, 16'hFFFC, 16'h0, 0, 0);
    chk("R2 disp words", used, 1);
    chk("R2 disp ext", ext_o, 32'hFFFFFFFC);
    chk("R2 disp tag", tag_o, 5);
    chk("R4 non-pc base", pc_base_o, 0);
    chk("R9 latency", cyc, 1);
    chk("R8 next_addr", next_addr_o, 32'h2002);
    run_op(3'd6, 3'd1, 2'd0, 32'h2100, 16'h8A05, 16'h0, 0, 0);
    chk("R2 index words", used, 1);
    chk("R2 index ext", ext_o, 32'h00008A05);
    chk("R2 index tag", tag_o, 6);
  endtask

  task automatic t_abs();
    run_op(3'd7, 3'd0, 2'd1, 32'h3000, 16'h8000, 16'h0, 0, 0);
    chk("R3 abs short ext", ext_o, 32'hFFFF8000);
    chk("R3 abs short tag", tag_o, 7);
    chk("R3 abs short words", used, 1);
    run_op(3'd7, 3'd1, 2'd0, 32'h3100, 16'h1234, 16'h5678, 0, 0);
    chk("R3 abs long ext", ext_o, 32'h12345678);
    chk("R3 abs long tag", tag_o, 8);
    chk("R3 abs long words", used, 2);
    chk("R8 abs long next", next_addr_o, 32'h3104);
  endtask

  task automatic t_pc();
    run_op(3'd7, 3'd2, 2'd1, 32'h1000, 16'hFFF0, 16'h0, 3, 0);
    chk("R4 pc disp base", pc_base_o, 32'h1000);
    chk("R4 pc disp ext", ext_o, 32'hFFFFFFF0);
    chk("R4 pc disp tag", tag_o, 9);
    chk("R7 stall latency", cyc, 4);
    chk("R8 pc next", next_addr_o, 32'h1002);
    run_op(3'd7, 3'd3, 2'd2, 32'h4FFE, 16'h3004, 16'h0, 0, 0);
    chk("R4 pc index base", pc_base_o, 32'h4FFE);
    chk("R4 pc index ext", ext_o, 32'h00003004);
    chk("R4 pc index tag", tag_o, 10);
    chk("R4 pc index words", used, 1);
  endtask

  task automatic t_imm();
    run_op(3'd7, 3'd4, 2'd2, 32'h5000, 16'hABCD, 16'hEF01, 0, 0);
    chk("R5 imm long ext", ext_o, 32'hABCDEF01);
    chk("R5 imm long words", used, 2);
    chk("R5 imm tag", tag_o, 11);
    run_op(3'd7, 3'd4, 2'd1, 32'h5100, 16'h8001, 16'h0, 0, 0);
    chk("R5 imm word ext", ext_o, 32'h00008001);
    chk("R5 imm word words", used, 1);
    run_op(3'd7, 3'd4, 2'd0, 32'h5200, 16'h00FF, 16'h0, 0, 0);
    chk("R5 imm byte ext", ext_o, 32'h000000FF);
    chk("R5 imm byte words", used, 1);
    run_op(3'd7, 3'd4, 2'd3, 32'h5300, 16'hF00F, 16'h0, 0, 0);
    chk("R5 imm size3 words", used, 1);
  endtask

  task automatic t_illegal();
    for (int r = 5; r < 8; r++) begin
      run_op(3'd7, 3'(r), 2'd2, 32'h6000, 16'h1234, 16'h5678, 0, 0);
      chk("R6 error", error_o, 1);
      chk("R6 tag", tag_o, 15);
      chk("R6 words", used, 0);
      chk("R6 latency", cyc, 0);
      chk("R6 next_addr", next_addr_o, 32'h6000);
    end
  endtask

  task automatic t_hold_busy_start();
    run_op(3'd7, 3'd1, 2'd2, 32'h7000, 16'hCAFE, 16'hF00D, 2, 1);
    chk("R9 busy start ignored tag", tag_o, 8);
    chk("R9 busy start ignored ext", ext_o, 32'hCAFEF00D);
    chk("R9 busy start ignored next", next_addr_o, 32'h7004);
    chk("R7 words bounded", used, 2);
    chk("R7 stall latency", cyc, 4);
    for (int i = 0; i < 3; i++) begin
      word_valid_i = 1'b1;
      word_data_i  = 16'h5A5A;
      @(negedge clk_i);
      chk("R9 done single pulse", done_o, 0);
      chk("R9 ready idle", word_ready_o, 0);
      chk("R9 hold ext", ext_o, 32'hCAFEF00D);
      chk("R9 hold next", next_addr_o, 32'h7004);
    end
    word_valid_i = 1'b0;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk_i);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_direct();
    t_disp_index();
    t_abs();
    t_pc();
    t_imm();
    t_illegal();
    t_hold_busy_start();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule